// File: doc/BRIEF.md
# Karatsuba Carry-Less Polynomial Multiplier

This block multiplies two polynomials with coefficients in GF(2), each held as an N-bit vector where bit i is the coefficient of x^i. Coefficient sums are exclusive-OR, so no carries ever propagate. The core is built by recursive elaboration. At each level both operands are cut into a low part of floor(w/2) bits and a high part of ceil(w/2) bits. The level then forms exactly three smaller products: high times high, low times low, and the product of the two part-sums. The cross term is recovered with XOR. Recursion stops once a part is no wider than a threshold parameter, and a plain AND/XOR schoolbook array handles that leaf.

The full product is 2N-1 bits wide. A parameter can add a fold stage that reduces the product modulo the trinomial x^N + x^TAP + 1, as needed when the multiplier serves field arithmetic. TAP defaults to 74 for N = 233. The result passes through one output register, which is qualified by a valid strobe. A new operand pair can be accepted every cycle.

Top module: `gf2k_mult`

## Requirements
- R1: With REDUCE = 0, `prod` equals the carry-less product of `a` and `b`. Bit k of `prod` is the XOR over all i + j = k of a[i]·b[j], for k from 0 to 2N-2.
- R2: The product is correct for every width, odd widths included. At each level the high part takes ceil(w/2) bits and the low part takes floor(w/2) bits. Levels no wider than THRESH use the schoolbook array.
- R3: `prod` and `out_valid` appear one clock edge after the edge that samples `in_valid` high with `a` and `b`. `out_valid` is 1 in that cycle.
- R4: After an edge with `in_valid` low, `out_valid` is 0 and `prod` keeps its previous value, whatever `a` and `b` hold.
- R5: After an edge with `rst` high, `out_valid` is 0 and `prod` is all zeros.
- R6: With REDUCE = 1, `prod` equals the carry-less product reduced modulo x^N + x^TAP + 1. Bits N through 2N-2 of `prod` are zero.
- R7: A zero operand gives a zero product.
- R8: Multiplying by the constant polynomial 1 (a = 1) returns `b` unchanged in the low N bits, with zeros above.
- R9: Single-term operands x^i and x^j give the single term x^(i+j), up to the top case x^(2N-2). All-ones operands give the product of the two all-ones polynomials.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair on `a`/`b` is to be multiplied |
| a | input | N | First operand polynomial, bit i is coefficient of x^i |
| b | input | N | Second operand polynomial |
| out_valid | output | 1 | `prod` was updated by the previous edge |
| prod | output | 2N-1 | Registered product, reduced when REDUCE = 1 |

## Verification
Two instances run side by side. One has an even width and no fold. The other has an odd width, so its splits are uneven at several depths, and it has the trinomial fold enabled. Single-term operands isolate the placement of each shifted partial product, and they reach the top coefficient and the fold taps exactly. All-ones operands make every cross term cancel or survive by parity, which exposes any missing XOR of the outer products into the middle term. The identity and zero operands, together with random pairs checked against a bit-serial shift-and-XOR model, separate wrong split boundaries from wrong recombination shifts. Idle and reset cycles show that the output register holds its value or clears.

// File: rtl/gf2k_pkg.sv
package gf2k_pkg;
  // width of a carry-less product of two w-bit polynomials
  function automatic int prod_width(input int w);
    return 2 * w - 1;
  endfunction
  // the split rule: the low part takes the floor half
  function automatic int low_half(input int w);
    return w / 2;
  endfunction
endpackage

// File: rtl/gf2k_school.sv
module gf2k_school #(
  parameter int W = 8
) (
  input  logic [W-1:0]                       a,
  input  logic [W-1:0]                       b,
  output logic [gf2k_pkg::prod_width(W)-1:0] p
);
  localparam int PW = gf2k_pkg::prod_width(W);

  always_comb begin
    p = '0;
    for (int i = 0; i < W; i++) begin
      if (b[i]) p = p ^ (PW'(a) << i);
    end
  end
endmodule

// File: rtl/gf2k_kara.sv
module gf2k_kara #(
  parameter int W      = 32,
  parameter int THRESH = 8
) (
  input  logic [W-1:0]                       a,
  input  logic [W-1:0]                       b,
  output logic [gf2k_pkg::prod_width(W)-1:0] p
);
  localparam int PW = gf2k_pkg::prod_width(W);

  generate
    if (W <= THRESH) begin : g_leaf
      gf2k_school #(.W(W)) u_leaf (.a(a), .b(b), .p(p));
    end else begin : g_split
      localparam int LO  = gf2k_pkg::low_half(W);
      localparam int HI  = W - LO;
      localparam int HPW = gf2k_pkg::prod_width(HI);
      localparam int LPW = gf2k_pkg::prod_width(LO);

      logic [HI-1:0]  a_hi, b_hi, a_sum, b_sum;
      logic [LO-1:0]  a_lo, b_lo;
      logic [HPW-1:0] pp_hi, pp_sum, mid;
      logic [LPW-1:0] pp_lo;

      assign a_hi  = a[W-1:LO];
      assign b_hi  = b[W-1:LO];
      assign a_lo  = a[LO-1:0];
      assign b_lo  = b[LO-1:0];
      assign a_sum = a_hi ^ HI'(a_lo);
      assign b_sum = b_hi ^ HI'(b_lo);

      gf2k_kara #(.W(HI), .THRESH(THRESH)) u_hi  (.a(a_hi),  .b(b_hi),  .p(pp_hi));
      gf2k_kara #(.W(LO), .THRESH(THRESH)) u_lo  (.a(a_lo),  .b(b_lo),  .p(pp_lo));
      gf2k_kara #(.W(HI), .THRESH(THRESH)) u_sum (.a(a_sum), .b(b_sum), .p(pp_sum));

      // cross term: sum product with both outer products cancelled
      assign mid = pp_sum ^ pp_hi ^ HPW'(pp_lo);

      assign p = {pp_hi, {(2 * LO){1'b0}}}
               ^ PW'({mid, {LO{1'b0}}})
               ^ PW'(pp_lo);
    end
  endgenerate
endmodule

// File: rtl/gf2k_trired.sv
module gf2k_trired #(
  parameter int N   = 32,
  parameter int TAP = 3
) (
  input  logic [gf2k_pkg::prod_width(N)-1:0] p_in,
  output logic [N-1:0]                       r_out
);
  localparam int PW = gf2k_pkg::prod_width(N);

  logic [PW-1:0] work;

  // fold from the top down: x^i = x^(i-N) * (x^TAP + 1)
  always_comb begin
    work = p_in;
    for (int i = PW - 1; i >= N; i--) begin
      if (work[i]) begin
        work[i]           = 1'b0;
        work[i - N]       = ~work[i - N];
        work[i - N + TAP] = ~work[i - N + TAP];
      end
    end
    r_out = work[N-1:0];
  end
endmodule

// File: rtl/gf2k_mult.sv
module gf2k_mult #(
  parameter int N      = 32,
  parameter int THRESH = 8,
  parameter bit REDUCE = 1'b0,
  parameter int TAP    = (N == 233) ? 74 : 3
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               in_valid,
  input  logic [N-1:0]                       a,
  input  logic [N-1:0]                       b,
  output logic                               out_valid,
  output logic [gf2k_pkg::prod_width(N)-1:0] prod
);
  localparam int PW = gf2k_pkg::prod_width(N);

  logic [PW-1:0] full;
  logic [PW-1:0] shaped;

  gf2k_kara #(.W(N), .THRESH(THRESH)) u_core (.a(a), .b(b), .p(full));

  generate
    if (REDUCE) begin : g_fold
      logic [N-1:0] rem;
      gf2k_trired #(.N(N), .TAP(TAP)) u_fold (.p_in(full), .r_out(rem));
      assign shaped = PW'(rem);
    end else begin : g_raw
      assign shaped = full;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      prod      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) prod <= shaped;
    end
  end
endmodule

// File: rtl/gf2k_mult_chk.sv
module gf2k_mult_chk #(
  parameter int N      = 32,
  parameter bit REDUCE = 1'b0
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               in_valid,
  input logic [N-1:0]                       a,
  input logic [N-1:0]                       b,
  input logic                               out_valid,
  input logic [gf2k_pkg::prod_width(N)-1:0] prod
);
  localparam int PW = gf2k_pkg::prod_width(N);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R5
  always_ff @(posedge clk) begin
    if (rst_q) begin
      reset_clear_chk: assert (!out_valid && prod == '0);
    end
  end

  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(prod)));

  // R7
  zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (a == '0 || b == '0)) |=> (prod == '0));

  // R8
  identity_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && a == N'(1)) |=> (prod == PW'($past(b))));

  generate
    if (REDUCE) begin : g_red_chk
      // R6
      reduced_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (prod[PW-1:N] == '0));
    end
  endgenerate
endmodule

bind gf2k_mult gf2k_mult_chk #(.N(N), .REDUCE(REDUCE)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b),
  .out_valid(out_valid), .prod(prod)
);

// File: tb/gf2k_mult_tb.sv
`timescale 1ns/1ps
module gf2k_mult_tb;
  localparam int NA  = 32;
  localparam int NB  = 29;
  localparam int TB  = 2;
  localparam int PWA = 2 * NA - 1;
  localparam int PWB = 2 * NB - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vin = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic ova, ovb;
  logic [PWA-1:0] pa;
  logic [PWB-1:0] pb;

  int nchk = 0;
  int nbad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  gf2k_mult #(.N(NA), .THRESH(8), .REDUCE(1'b0)) u_dut (
    .clk(clk), .rst(rst), .in_valid(vin), .a(opa[NA-1:0]), .b(opb[NA-1:0]),
    .out_valid(ova), .prod(pa));

  gf2k_mult #(.N(NB), .THRESH(4), .REDUCE(1'b1), .TAP(TB)) u_red (
    .clk(clk), .rst(rst), .in_valid(vin), .a(opa[NB-1:0]), .b(opb[NB-1:0]),
    .out_valid(ovb), .prod(pb));

  function automatic logic [127:0] ref_mul(logic [63:0] x, logic [63:0] y, int n);
    logic [127:0] acc = '0;
    for (int i = 0; i < n; i++)
      if (y[i]) acc = acc ^ ({64'd0, x & ((64'd1 << n) - 1)} << i);
    return acc;
  endfunction

  function automatic logic [127:0] ref_fold(logic [127:0] v, int n, int t);
    logic [127:0] w = v;
    for (int i = 2 * n - 2; i >= n; i--)
      if (w[i]) begin
        w[i] = 1'b0;
        w[i - n] = ~w[i - n];
        w[i - n + t] = ~w[i - n + t];
      end
    return w;
  endfunction

  task automatic check(string tag, logic [127:0] got, logic [127:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // drive one pair and compare both instances one edge later
  task automatic apply(string tag, logic [63:0] x, logic [63:0] y);
    @(negedge clk);
    opa = x; opb = y; vin = 1'b1;
    @(negedge clk);
    vin = 1'b0;
    check({tag, " R3 valid"}, {127'd0, ova & ovb}, 128'd1);
    check({tag, " R1 raw"}, 128'(pa), ref_mul(x, y, NA));
    check({tag, " R6 R2 fold"}, 128'(pb), ref_fold(ref_mul(x, y, NB), NB, TB));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 reset valid", {126'd0, ova, ovb}, 128'd0);
    check("R5 reset prod", 128'(pa) | 128'(pb), 128'd0);
    rst = 1'b0;
  endtask

  task automatic t_identity();
    apply("R8 identity", 64'd1, 64'h0123_4567_89ab_cdef);
    check("R8 identity value", 128'(pa), 128'h89ab_cdef);
  endtask

  task automatic t_zero();
    apply("R7 zero", 64'd0, 64'hffff_ffff_ffff_ffff);
    check("R7 zero value", 128'(pa) | 128'(pb), 128'd0);
  endtask

  task automatic t_single_bits();
    apply("R9 top term", 64'd1 << (NA - 1), 64'd1 << (NA - 1));
    check("R9 top coefficient", 128'(pa), 128'd1 << (2 * NA - 2));
    for (int i = 0; i < NB; i += 7)
      for (int j = 3; j < NB; j += 9)
        apply("R9 single", 64'd1 << i, 64'd1 << j);
  endtask

  task automatic t_all_ones();
    apply("R9 all ones", 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff);
    apply("R9 ones by one-bit", 64'hffff_ffff_ffff_ffff, 64'd1 << 5);
  endtask

  task automatic t_random();
    for (int k = 0; k < 40; k++)
      apply("R1 R2 random", {$urandom, $urandom}, {$urandom, $urandom});
  endtask

  task automatic t_hold();
    logic [PWA-1:0] keep_a;
    logic [PWB-1:0] keep_b;
    apply("R4 setup", 64'h00c0_ffee_1234_5678, 64'h0000_0000_dead_beef);
    keep_a = pa; keep_b = pb;
    @(negedge clk);
    opa = 64'hffff_0000_ffff_0000; opb = 64'h1357_9bdf_2468_ace0;
    repeat (2) @(negedge clk);
    check("R4 idle valid", {126'd0, ova, ovb}, 128'd0);
    check("R4 held raw", 128'(pa), 128'(keep_a));
    check("R4 held fold", 128'(pb), 128'(keep_b));
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nchk++; nbad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_identity();
    t_zero();
    t_single_bits();
    t_all_ones();
    t_random();
    t_hold();
    apply("R5 pre-reset", 64'h5555_aaaa_5555_aaaa, 64'h0f0f_0f0f_0f0f_0f0f);
    t_reset();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule